// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer with Quadrature Decoding

This block is a general-purpose 16-bit timer. A counter steps up or down between zero and a reload limit, paced by a prescaler that divides the clock by a power of two. Two channels sit beside the counter. Each channel either records the count when its input pin changes, toggles its output pin when the count reaches a programmed value, or drives a pulse-width waveform. A decoder mode instead lets the two channel pins, read as a quadrature pair, move the counter up and down.

A trigger pin can clear the counter, gate it, start it, or act as its clock. A break pin forces both channel outputs inactive. Software writes and reads eight 16-bit registers through a simple synchronous port. Seven sticky event flags are brought out directly as interrupt lines.

Register map (address: contents): 0 control (bit0 run, bit1 count down, bits4:2 prescaler code, bits6:5 trigger role 0 none / 1 clear / 2 gate / 3 start, bit7 quadrature decoding, bit8 trigger is the count clock); 1 reload limit; 2 and 3 channel 0 and 1 setup (bits1:0 role 0 off / 1 capture / 2 toggle-on-match / 3 PWM, bit2 capture on falling edge); 4 and 5 channel 0 and 1 match/capture value; 6 event flags; 7 counter.

Top module: `gp_timer16`

## Requirements
- R1: Counting up, the counter goes from the reload limit to 0 on its next step. Counting down, it goes from 0 to the reload limit. Either wrap is an update event and sets flag bit0.
- R2: With prescaler code k (bits4:2 of register 0), the counter takes one step every 2^k clock cycles while running (k = 0 to 7).
- R3: Writes to the reload limit and the prescaler code take effect only at the next update event. A write to the counter register loads the written value and is itself an update event that also clears the prescaler.
- R4: In PWM role, the channel output is 1 exactly while the counter is below the match value. A match value of 0 keeps the output at 0.
- R5: In toggle role, the output inverts and flag bit1 (channel 0) or bit2 (channel 1) is set on the step that brings the counter to the match value.
- R6: In capture role, the selected edge of the channel input latches the counter value from before that clock's step into the match/capture register and sets the channel flag. A read of that register with rdEn high clears the channel flag.
- R7: A capture while the channel flag is still set also sets the over-capture flag: bit3 for channel 0, bit4 for channel 1.
- R8: In quadrature mode (bit7), a single-bit change of the input pair moves the counter by one. It counts up when the new chIn[0] differs from the previous chIn[1]. A change of both bits at once leaves the counter unchanged.
- R9: Trigger role "clear": a rising trigger edge sets the counter to 0 (counting up) on that clock.
- R10: Trigger role "gate": the counter steps only while trigIn is high.
- R11: Trigger role "start": a rising trigger edge sets the run bit. Any rising trigger edge sets flag bit5.
- R12: With bit8 set, the counter takes one step per rising trigger edge, however long the pin stays high.
- R13: While brkIn is high, both channel outputs are 0, and flag bit6 is set and stays set.
- R14: Writing register 6 clears exactly those flags whose bits are written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdEn | input | 1 | Read strobe (clears a capture flag on a capture register read) |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| chIn | input | 2 | Channel input pins / quadrature pair |
| trigIn | input | 1 | External trigger pin |
| brkIn | input | 1 | Break pin |
| chOut | output | 2 | Channel output pins |
| irqFlags | output | 7 | Sticky event flags |

## Verification
The assertions check four things on every cycle: outputs held low under break, the break and update flags being set, the counter never jumping by more than one without an update event, and over-capture never rising without a pending capture. They also check that illegal double transitions in quadrature mode leave the count alone. The bench scenarios are needed for the rest. These are the prescaler period, the deferred reload and prescaler loads, the PWM duty and toggle timing, the captured values, and each trigger role. They also cover the count tracked over a random quadrature walk with wrap-around.

// File: rtl/gp_timer16_pkg.sv
package gp_timer16_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CH0   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CCR0  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd7;

  localparam int FLAG_W = 7;

  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_TOGGLE  = 2'd2,
    CH_PWM     = 2'd3
  } chRole_e;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'd0,
    TRG_CLEAR = 2'd1,
    TRG_GATE  = 2'd2,
    TRG_START = 2'd3
  } trgRole_e;

  typedef struct packed {
    logic       tick;
    logic       down;
    logic       cntWrite;
    logic       trgClear;
    logic       trigRise;
    logic [1:0] chRise;
    logic [1:0] chFall;
  } strobes_t;
endpackage

// File: rtl/gp_timer16_ctrl.sv
module gp_timer16_ctrl
  import gp_timer16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 trigIn,
  input  logic [1:0]           chIn,
  input  logic                 updEvt,
  output strobes_t             strb,
  output logic [DATA_W-1:0]    cfgWord,
  output logic                 encMode,
  output logic [1:0]           chPrev
);
  localparam int PSC_W = (1 << CODE_W) - 1;

  logic              runQ, downQ, encQ, extQ;
  logic [CODE_W-1:0] codeShadow, codeLive;
  trgRole_e          trgRole;
  logic [PSC_W-1:0]  pscCnt, pscMask;
  logic              trigQ;
  logic [1:0]        chQ;

  logic cfgWr, trigRise, running, pscHit, encUp;
  logic [1:0] encDelta;

  assign cfgWr    = wrEn && (wrAddr == ADDR_CFG);
  assign trigRise = trigIn & ~trigQ;
  assign running  = runQ && ((trgRole != TRG_GATE) || trigIn);
  assign pscMask  = (PSC_W'(1) << codeLive) - PSC_W'(1);
  assign pscHit   = (pscCnt == pscMask);
  assign encDelta = chIn ^ chQ;
  assign encUp    = chIn[0] ^ chQ[1];

  always_comb begin
    strb          = '0;
    strb.trigRise = trigRise;
    strb.chRise   = chIn & ~chQ;
    strb.chFall   = ~chIn & chQ;
    strb.cntWrite = wrEn && (wrAddr == ADDR_CNT);
    strb.trgClear = (trgRole == TRG_CLEAR) && trigRise;
    if (encQ) begin
      strb.tick = running && (encDelta == 2'b01 || encDelta == 2'b10);
      strb.down = ~encUp;
    end else begin
      strb.tick = running && (extQ ? trigRise : pscHit);
      strb.down = downQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0; downQ <= 1'b0; encQ <= 1'b0; extQ <= 1'b0;
      codeShadow <= '0; codeLive <= '0; trgRole <= TRG_NONE;
      pscCnt <= '0; trigQ <= 1'b0; chQ <= '0;
    end else begin
      trigQ <= trigIn;
      chQ   <= chIn;
      if (cfgWr) begin
        runQ       <= wrData[0];
        downQ      <= wrData[1];
        codeShadow <= wrData[4:2];
        trgRole    <= trgRole_e'(wrData[6:5]);
        encQ       <= wrData[7];
        extQ       <= wrData[8];
      end else if (trgRole == TRG_START && trigRise) begin
        runQ <= 1'b1;
      end
      if (updEvt) begin
        codeLive <= codeShadow;
        pscCnt   <= '0;
      end else if (running && !encQ && !extQ) begin
        pscCnt <= pscHit ? '0 : pscCnt + PSC_W'(1);
      end
    end
  end

  assign cfgWord = {{(DATA_W-9){1'b0}}, extQ, encQ, trgRole, codeShadow, downQ, runQ};
  assign encMode = encQ;
  assign chPrev  = chQ;
endmodule

// File: rtl/gp_timer16_dp.sv
module gp_timer16_dp
  import gp_timer16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  strobes_t          strb,
  input  logic              brkIn,
  output logic [DATA_W-1:0] cntVal,
  output logic              updEvt,
  output logic [NUM_CH-1:0] chOut,
  output logic [FLAG_W-1:0] flags,
  output logic [DATA_W-1:0] regRd
);
  logic [DATA_W-1:0] limShadow, limLive, cntQ, cntNext;
  logic              stepEv;
  logic [FLAG_W-1:0] flagQ, flagSet, flagClr;
  logic [NUM_CH-1:0] ccSet, ovcSet, ccRdClr;
  logic [DATA_W-1:0] ccrAll [NUM_CH];
  logic [2:0]        chCfgAll [NUM_CH];

  always_comb begin
    cntNext = cntQ;
    updEvt  = 1'b0;
    stepEv  = 1'b0;
    if (strb.cntWrite) begin
      cntNext = wrData;
      updEvt  = 1'b1;
    end else if (strb.trgClear) begin
      cntNext = strb.down ? limShadow : '0;
      updEvt  = 1'b1;
    end else if (strb.tick) begin
      stepEv = 1'b1;
      if (strb.down) begin
        if (cntQ == '0) begin cntNext = limLive; updEvt = 1'b1; end
        else cntNext = cntQ - DATA_W'(1);
      end else begin
        if (cntQ >= limLive) begin cntNext = '0; updEvt = 1'b1; end
        else cntNext = cntQ + DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limShadow <= '1; limLive <= '1; cntQ <= '0; flagQ <= '0;
    end else begin
      cntQ <= cntNext;
      if (wrEn && wrAddr == ADDR_LIMIT) limShadow <= wrData;
      if (updEvt) limLive <= limShadow;
      flagQ <= (flagQ & ~flagClr) | flagSet;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [DATA_W-1:0] ccrQ;
    chRole_e           role;
    logic              fallSel, toggleQ, capEv, cmpEv;

    assign capEv = (role == CH_CAPTURE) && (fallSel ? strb.chFall[g] : strb.chRise[g]);
    assign cmpEv = stepEv && (role == CH_TOGGLE || role == CH_PWM) && (cntNext == ccrQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ccrQ <= '0; role <= CH_OFF; fallSel <= 1'b0; toggleQ <= 1'b0;
      end else begin
        if (capEv) ccrQ <= cntQ;
        else if (wrEn && wrAddr == ADDR_CCR0 + ADDR_W'(g)) ccrQ <= wrData;
        if (wrEn && wrAddr == ADDR_CH0 + ADDR_W'(g)) begin
          role    <= chRole_e'(wrData[1:0]);
          fallSel <= wrData[2];
          toggleQ <= 1'b0;
        end else if (cmpEv && role == CH_TOGGLE) begin
          toggleQ <= ~toggleQ;
        end
      end
    end

    assign chOut[g]    = ~brkIn & ((role == CH_PWM) ? (cntQ < ccrQ) :
                                   (role == CH_TOGGLE) ? toggleQ : 1'b0);
    assign ccSet[g]    = capEv | cmpEv;
    assign ovcSet[g]   = capEv & flagQ[1+g];
    assign ccRdClr[g]  = rdEn && (rdAddr == ADDR_CCR0 + ADDR_W'(g)) && (role == CH_CAPTURE);
    assign ccrAll[g]   = ccrQ;
    assign chCfgAll[g] = {fallSel, role};
  end

  assign flagSet = {brkIn, strb.trigRise, ovcSet, ccSet, updEvt};
  assign flagClr = ((wrEn && wrAddr == ADDR_FLAGS) ? wrData[FLAG_W-1:0] : '0)
                 | {{(FLAG_W-1-NUM_CH){1'b0}}, ccRdClr, 1'b0};

  always_comb begin
    case (rdAddr)
      ADDR_LIMIT:      regRd = limShadow;
      ADDR_CH0:        regRd = DATA_W'(chCfgAll[0]);
      ADDR_CH0 + 3'd1: regRd = DATA_W'(chCfgAll[1]);
      ADDR_CCR0:       regRd = ccrAll[0];
      ADDR_CCR0 + 3'd1:regRd = ccrAll[1];
      ADDR_FLAGS:      regRd = DATA_W'(flagQ);
      ADDR_CNT:        regRd = cntQ;
      default:         regRd = '0;
    endcase
  end

  assign cntVal = cntQ;
  assign flags  = flagQ;
endmodule

// File: rtl/gp_timer16.sv
module gp_timer16
  import gp_timer16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [15:0]       wrData,
  input  logic              rdEn,
  input  logic [2:0]        rdAddr,
  output logic [15:0]       rdData,
  input  logic [1:0]        chIn,
  input  logic              trigIn,
  input  logic              brkIn,
  output logic [1:0]        chOut,
  output logic [6:0]        irqFlags
);
  strobes_t          strb;
  logic              updEvt, encMode;
  logic [1:0]        chPrev;
  logic [DATA_W-1:0] cfgWord, regRd, cntVal;

  gp_timer16_ctrl #(.DATA_W(DATA_W), .CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigIn(trigIn), .chIn(chIn), .updEvt(updEvt), .strb(strb),
    .cfgWord(cfgWord), .encMode(encMode), .chPrev(chPrev)
  );

  gp_timer16_dp #(.DATA_W(DATA_W), .NUM_CH(2)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb), .brkIn(brkIn),
    .cntVal(cntVal), .updEvt(updEvt), .chOut(chOut), .flags(irqFlags),
    .regRd(regRd)
  );

  assign rdData = (rdAddr == ADDR_CFG) ? cfgWord : regRd;
endmodule

// File: rtl/gp_timer16_chk.sv
module gp_timer16_chk (
  input logic        clk,
  input logic        rstN,
  input logic        brkIn,
  input logic [1:0]  chIn,
  input logic [1:0]  chPrev,
  input logic        encMode,
  input logic        updEvt,
  input logic [15:0] cnt,
  input logic [1:0]  chOut,
  input logic [6:0]  flags
);
  // R13
  a_r13_break_blocks_outputs: assert property (@(posedge clk) disable iff (!rstN)
    brkIn |-> chOut == 2'b00);
  // R13
  a_r13_break_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    brkIn |=> flags[6]);
  // R1
  a_r1_update_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> flags[0]);
  // R1 R8: without an update event the count moves by at most one
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !updEvt |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == $past(cnt) - 16'd1));
  // R8
  a_r8_double_flip_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (encMode && ((chIn ^ chPrev) == 2'b11) && !updEvt) |=> cnt == $past(cnt));
  // R7
  a_r7_ovc0_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[3]) |-> $past(flags[1]));
  // R7
  a_r7_ovc1_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[4]) |-> $past(flags[2]));
endmodule

bind gp_timer16 gp_timer16_chk uChk (
  .clk(clk), .rstN(rstN), .brkIn(brkIn), .chIn(chIn), .chPrev(chPrev),
  .encMode(encMode), .updEvt(updEvt), .cnt(cntVal), .chOut(chOut), .flags(irqFlags)
);

// File: tb/gp_timer16_test.sv
module gp_timer16_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 0, A_LIM = 1, A_CH0 = 2, A_CH1 = 3,
                         A_CC0 = 4, A_CC1 = 5, A_FLG = 6, A_CNT = 7;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, trigIn = 0, brkIn = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [15:0] wrData = 0, rdData;
  logic [1:0] chIn = 0, chOut;
  logic [6:0] irqFlags;
  int checks = 0, failures = 0;
  bit done = 0;

  gp_timer16 uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .chIn(chIn), .trigIn(trigIn),
    .brkIn(brkIn), .chOut(chOut), .irqFlags(irqFlags));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic rdClr(input logic [2:0] a, output logic [15:0] v);
    rdAddr = a; rdEn = 1; #1; v = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  function automatic logic [15:0] cfgVal(int code, bit down, int trg, bit enc, bit ext);
    return 16'((ext << 8) | (enc << 7) | (trg << 5) | (code << 2) | (down << 1));
  endfunction

  function automatic int expUp(int n, int k, int lim);
    return (n >> k) % (lim + 1);
  endfunction

  function automatic logic [1:0] gray(int i);
    case (i & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic startRun(input logic [15:0] cfg, input int lim, input int start);
    wr(A_CFG, cfg);
    wr(A_LIM, 16'(lim));
    wr(A_CNT, 16'(start));
    wr(A_CFG, cfg | 16'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int bad, pos, idx;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    peek(A_CNT, v); chk("reset cnt", v, 0);
    peek(A_LIM, v); chk("reset limit", v, 16'hFFFF);
    peek(A_FLG, v); chk("reset flags", v, 0);
    peek(A_CFG, v); chk("reset cfg", v, 0);
    chk("reset outputs", chOut, 0);

    // R2 R1: prescaled up count and wrap
    startRun(cfgVal(1, 0, 0, 0, 0), 9, 0);
    repeat (7) @(negedge clk);
    peek(A_CNT, v); chk("R2 prescale /2", v, 3);
    wr(A_FLG, 16'h7F);
    repeat (13) @(negedge clk);
    peek(A_CNT, v); chk("R1 up wrap", v, expUp(21, 1, 9));
    peek(A_FLG, v); chk("R1 update flag", v & 1, 1);

    // R2: random prescaler codes and limits
    for (int i = 0; i < 8; i++) begin
      int k, lim, n;
      k = i; lim = 3 + ($urandom % 30); n = 20 + ($urandom % 280);
      startRun(cfgVal(k, 0, 0, 0, 0), lim, 0);
      repeat (n) @(negedge clk);
      peek(A_CNT, v); chk($sformatf("R2 code %0d", k), v, expUp(n, k, lim));
    end

    // R1: down count with underflow
    startRun(cfgVal(0, 1, 0, 0, 0), 5, 5);
    wr(A_FLG, 16'h7F);
    repeat (2) @(negedge clk);
    peek(A_CNT, v); chk("R1 down", v, 2);
    peek(A_FLG, v); chk("R1 no update yet", v & 1, 0);
    repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R1 underflow reload", v, 4);
    peek(A_FLG, v); chk("R1 underflow flag", v & 1, 1);

    // R3: shadowed limit
    startRun(cfgVal(0, 0, 0, 0, 0), 9, 0);
    repeat (2) @(negedge clk);
    wr(A_LIM, 16'd3);
    repeat (5) @(negedge clk);
    peek(A_CNT, v); chk("R3 old limit kept", v, 8);
    repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R3 after update", v, 2);
    repeat (2) @(negedge clk);
    peek(A_CNT, v); chk("R3 new limit", v, 0);

    // R4: PWM
    wr(A_CH0, 16'd3);
    wr(A_CC0, 16'd4);
    startRun(cfgVal(0, 0, 0, 0, 0), 9, 0);
    for (int r = 0; r < 5; r++) begin
      int cc;
      cc = (r == 0) ? 0 : (r == 1) ? 15 : int'($urandom % 11);
      wr(A_CC0, 16'(cc));
      bad = 0;
      for (int c = 0; c < 25; c++) begin
        peek(A_CNT, v);
        if (chOut[0] != (int'(v) < cc)) bad++;
        @(negedge clk);
      end
      chk($sformatf("R4 pwm mismatches ccr=%0d", cc), bad, 0);
    end
    wr(A_CH0, 16'd0);

    // R5: toggle on match
    wr(A_CH1, 16'd2);
    wr(A_CC1, 16'd6);
    startRun(cfgVal(0, 0, 0, 0, 0), 9, 0);
    wr(A_FLG, 16'h7F);
    repeat (4) @(negedge clk);
    chk("R5 before match", chOut[1], 0);
    @(negedge clk);
    chk("R5 toggled", chOut[1], 1);
    peek(A_FLG, v); chk("R5 match flag", (v >> 2) & 1, 1);
    repeat (10) @(negedge clk);
    chk("R5 toggled back", chOut[1], 0);

    // R6 R7: capture
    wr(A_CH0, 16'd1);
    wr(A_CH1, 16'd5);
    startRun(cfgVal(0, 0, 0, 0, 0), 1000, 0);
    wr(A_FLG, 16'h7F);
    repeat (9) @(negedge clk);
    begin
      logic [15:0] c0;
      peek(A_CNT, c0); chIn[0] = 1; @(negedge clk);
      peek(A_CC0, v); chk("R6 rising capture", v, c0);
      peek(A_FLG, v); chk("R6 capture flag", (v >> 1) & 1, 1);
      rdClr(A_CC0, v);
      peek(A_FLG, v); chk("R6 read clears flag", (v >> 1) & 1, 0);
      chIn[0] = 0; @(negedge clk);
      chIn[0] = 1; @(negedge clk);
      chIn[0] = 0; @(negedge clk);
      peek(A_FLG, v); chk("R7 no overcapture", (v >> 3) & 1, 0);
      peek(A_CNT, c0); chIn[0] = 1; @(negedge clk);
      peek(A_CC0, v); chk("R6 second capture", v, c0);
      peek(A_FLG, v); chk("R7 overcapture", (v >> 3) & 1, 1);
      chIn[1] = 1; @(negedge clk);
      peek(A_FLG, v); chk("R6 rise ignored on falling channel", (v >> 2) & 1, 0);
      peek(A_CNT, c0); chIn[1] = 0; @(negedge clk);
      peek(A_CC1, v); chk("R6 falling capture", v, c0);
    end
    wr(A_CH0, 16'd0); wr(A_CH1, 16'd0);
    chIn = 0;
    repeat (2) @(negedge clk);

    // R8: quadrature walk
    startRun(cfgVal(0, 0, 0, 1, 0), 9, 2);
    pos = 2; idx = 0; bad = 0;
    for (int s = 0; s < 80; s++) begin
      int r;
      r = $urandom % 5;
      if (r < 2) begin idx = idx + 1; pos = (pos + 1) % 10; end
      else if (r < 4) begin idx = idx + 3; pos = (pos + 9) % 10; end
      else idx = idx + 2;
      chIn = gray(idx);
      @(negedge clk);
      peek(A_CNT, v);
      if (int'(v) != pos) bad++;
    end
    chk("R8 quadrature mismatches", bad, 0);
    peek(A_CNT, v); chk("R8 final position", v, pos);
    chIn = 0;
    repeat (2) @(negedge clk);

    // R9: trigger clears
    startRun(cfgVal(0, 0, 1, 0, 0), 99, 0);
    wr(A_FLG, 16'h7F);
    repeat (20) @(negedge clk);
    trigIn = 1; @(negedge clk);
    peek(A_CNT, v); chk("R9 cleared", v, 0);
    peek(A_FLG, v); chk("R11 trigger flag", (v >> 5) & 1, 1);
    repeat (3) @(negedge clk);
    peek(A_CNT, v); chk("R9 resumes", v, 3);
    trigIn = 0;

    // R10: gate
    startRun(cfgVal(0, 0, 2, 0, 0), 99, 0);
    repeat (5) @(negedge clk);
    peek(A_CNT, v); chk("R10 gate closed", v, 0);
    trigIn = 1; repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R10 gate open", v, 4);
    trigIn = 0; repeat (3) @(negedge clk);
    peek(A_CNT, v); chk("R10 gate closed again", v, 4);

    // R11: trigger start
    wr(A_CFG, cfgVal(0, 0, 3, 0, 0));
    wr(A_CNT, 16'd0);
    repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R11 idle before trigger", v, 0);
    trigIn = 1; @(negedge clk);
    repeat (5) @(negedge clk);
    peek(A_CNT, v); chk("R11 started", v, 5);
    peek(A_CFG, v); chk("R11 run bit", v & 1, 1);
    trigIn = 0;

    // R12: trigger as clock
    startRun(cfgVal(0, 0, 0, 0, 1), 99, 0);
    for (int p = 0; p < 6; p++) begin
      trigIn = 1; @(negedge clk); trigIn = 0; @(negedge clk);
    end
    trigIn = 1; repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R12 edge count", v, 7);
    trigIn = 0;

    // R13 R14: break and flag clearing
    wr(A_CH0, 16'd3);
    wr(A_CC0, 16'd50);
    startRun(cfgVal(0, 0, 0, 0, 0), 99, 0);
    wr(A_FLG, 16'h7F);
    chk("R13 output before break", chOut[0], 1);
    brkIn = 1; #1;
    chk("R13 output forced low", chOut[0], 0);
    @(negedge clk);
    brkIn = 0; @(negedge clk);
    peek(A_FLG, v); chk("R13 break flag sticky", (v >> 6) & 1, 1);
    chk("R13 output restored", chOut[0], 1);
    trigIn = 1; @(negedge clk); trigIn = 0;
    wr(A_FLG, 16'h40);
    peek(A_FLG, v); chk("R14 selective clear", v & 16'h60, 16'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule